// File: doc/BRIEF.md
# Memory Request Channel Splitter

This block sits between the client request port of a multi-channel memory controller and its per-channel schedulers. It takes one client request, made of an id, a read/write flag, a byte address and a length in 32-byte bursts. It cuts that request into sub-requests, one for each stretch of the request that falls inside one channel-interleave granule. Each sub-request names its target channel and the bank, row and column it reaches. It also carries the parent id, a sequence number and a burst count.

Requests enter through a valid/ready handshake and leave through another one toward the schedulers. A read piece is only presented while the read-buffer pool signals that an entry is available. When the piece is taken, the block raises a one-cycle reservation strobe so that the pool can claim the entry. A stalled request holds its remaining part internally until the downstream side can take it. With the default parameters there are 8 channels, the granule is 8 bursts (256 bytes), and the column, bank and row fields sit above the channel field.

Top module: `memreq_splitter`

## Requirements
- R1: Out of reset, `subValid` and `rbReserve` are 0 and `reqReady` is 1.
- R2: `reqReady` is 1 only while no request is being split, and a request is taken on a clock edge where `reqValid` and `reqReady` are both 1. `reqValid` has no effect while `reqReady` is 0.
- R3: The address decodes over burst-address bits `ba = reqAddr[27:5]`, and `reqAddr[4:0]` is ignored. The fields are channel = `ba[5:3]`, bank = `ba[8:6]`, column = `{ba[14:9], ba[2:0]}` (in bursts) and row = `ba[22:15]`. Each piece's fields are taken from the burst address of its first burst.
- R4: Each piece carries `subBursts = min(remaining, 8 - ba[2:0])`. Pieces come out in ascending address order, and their burst counts add up to the request length.
- R5: Every piece repeats the request id and write flag, and `subSeq` counts 0, 1, 2 and so on in split order.
- R6: While `subValid` is 1 and `subReady` is 0, `subValid` stays 1 and every sub-request field holds its value.
- R7: A read piece (`reqWrite` = 0) is presented only while `rbAvail` is 1. A write piece is presented regardless of `rbAvail`.
- R8: `rbReserve` is 1 exactly in the cycles where a read piece is handed off (`subValid` and `subReady` both 1). It is never 1 for a write.
- R9: In the cycle after the last piece is handed off, `subValid` is 0 and `reqReady` is 1.
- R10: A request with a length of 0 bursts is accepted and produces no piece. `reqReady` is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Client request valid |
| reqReady | output | 1 | Splitter can take a request |
| reqId | input | ID_W | Request id |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address, burst aligned |
| reqBursts | input | LEN_W | Length in 32-byte bursts |
| subValid | output | 1 | Sub-request valid |
| subReady | input | 1 | Channel scheduler takes the sub-request |
| subChannel | output | CH_W | Target channel |
| subId | output | ID_W | Parent request id |
| subSeq | output | SEQ_W | Piece index within the request |
| subWrite | output | 1 | Write flag of the piece |
| subBank | output | BANK_W | Bank field |
| subRow | output | ROW_W | Row field |
| subCol | output | COL_W | Column field in bursts |
| subBursts | output | GRAN_LG+1 | Burst count of the piece |
| rbAvail | input | 1 | A read-buffer entry is free |
| rbReserve | output | 1 | Claim a read-buffer entry this cycle |

## Verification
The sweep covers every starting burst position inside two granules with every length from 0 to 31, for both reads and writes. This puts pieces on each side of a granule boundary, exact fits, single bursts and requests of five pieces. A wrong minimum in the piece size would produce a piece that crosses into the next channel, or a burst total that does not match the request. A wrong field decode would send pieces to a neighbouring channel or bank. Interleaved stalls check three more failure modes: a read that escapes with no buffer entry free, fields that drift while the scheduler holds off, and a reservation strobe that fires on a write. A design that miscounted the tail would show up as a lost or extra piece, or as a late return of `reqReady`.

// File: rtl/mreq_split_pkg.sv
package mreq_split_pkg;

  // strobes from control into the datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // current piece handed off
  } split_strobe_t;

  // status from the datapath back to control
  typedef struct packed {
    logic isWrite;
    logic lastPiece;
  } split_status_t;

endpackage

// File: rtl/mreq_split_ctrl.sv
module mreq_split_ctrl
  import mreq_split_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqEmpty,
  input  logic          subReady,
  input  logic          rbAvail,
  input  split_status_t status,
  output logic          reqReady,
  output logic          subValid,
  output logic          rbReserve,
  output split_strobe_t strobe
);

  logic busy;

  always_comb begin
    reqReady       = !busy;
    subValid       = busy && (status.isWrite || rbAvail);
    strobe.load    = reqValid && !busy;
    strobe.advance = subValid && subReady;
    rbReserve      = strobe.advance && !status.isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strobe.load) begin
      busy <= !reqEmpty;
    end else if (strobe.advance && status.lastPiece) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/mreq_split_dp.sv
module mreq_split_dp
  import mreq_split_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int ID_W     = 8,
  parameter int LEN_W    = 5,
  parameter int BURST_LG = 5,
  parameter int GRAN_LG  = 3,
  parameter int CH_W     = 3,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 8,
  parameter int SEQ_W    = 3,
  localparam int BA_W    = ADDR_W - BURST_LG,
  localparam int CNT_W   = GRAN_LG + 1,
  localparam int COLHI_W = BA_W - GRAN_LG - CH_W - BANK_W - ROW_W,
  localparam int COL_W   = COLHI_W + GRAN_LG
) (
  input  logic               clk,
  input  logic               rstN,
  input  split_strobe_t      strobe,
  input  logic [ID_W-1:0]    reqId,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]   reqBursts,
  output split_status_t      status,
  output logic [CH_W-1:0]    subChannel,
  output logic [ID_W-1:0]    subId,
  output logic [SEQ_W-1:0]   subSeq,
  output logic               subWrite,
  output logic [BANK_W-1:0]  subBank,
  output logic [ROW_W-1:0]   subRow,
  output logic [COL_W-1:0]   subCol,
  output logic [CNT_W-1:0]   subBursts
);

  localparam int CH_LO    = GRAN_LG;
  localparam int BANK_LO  = CH_LO + CH_W;
  localparam int COLHI_LO = BANK_LO + BANK_W;
  localparam int ROW_LO   = COLHI_LO + COLHI_W;
  localparam int GRAN     = 1 << GRAN_LG;

  logic [BA_W-1:0]  burstAddr;
  logic [LEN_W-1:0] remain;
  logic [ID_W-1:0]  idReg;
  logic [SEQ_W-1:0] seqReg;
  logic             wrReg;

  logic [CNT_W-1:0] granLeft;
  logic [CNT_W-1:0] pieceLen;
  logic             tailFits;

  always_comb begin
    granLeft  = CNT_W'(GRAN) - {1'b0, burstAddr[GRAN_LG-1:0]};
    tailFits  = remain <= LEN_W'(granLeft);
    pieceLen  = tailFits ? CNT_W'(remain) : granLeft;

    status.isWrite   = wrReg;
    status.lastPiece = tailFits;

    subChannel = burstAddr[CH_LO +: CH_W];
    subBank    = burstAddr[BANK_LO +: BANK_W];
    subRow     = burstAddr[ROW_LO +: ROW_W];
    subCol     = {burstAddr[COLHI_LO +: COLHI_W], burstAddr[GRAN_LG-1:0]};
    subBursts  = pieceLen;
    subId      = idReg;
    subSeq     = seqReg;
    subWrite   = wrReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstAddr <= '0;
      remain    <= '0;
      idReg     <= '0;
      seqReg    <= '0;
      wrReg     <= 1'b0;
    end else if (strobe.load) begin
      burstAddr <= reqAddr[ADDR_W-1:BURST_LG];
      remain    <= reqBursts;
      idReg     <= reqId;
      seqReg    <= '0;
      wrReg     <= reqWrite;
    end else if (strobe.advance) begin
      burstAddr <= burstAddr + BA_W'(pieceLen);
      remain    <= remain - LEN_W'(pieceLen);
      seqReg    <= seqReg + 1'b1;
    end
  end

endmodule

// File: rtl/memreq_splitter.sv
module memreq_splitter
  import mreq_split_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int ID_W     = 8,
  parameter int LEN_W    = 5,
  parameter int BURST_LG = 5,
  parameter int GRAN_LG  = 3,
  parameter int CH_W     = 3,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 8,
  localparam int BA_W       = ADDR_W - BURST_LG,
  localparam int CNT_W      = GRAN_LG + 1,
  localparam int COLHI_W    = BA_W - GRAN_LG - CH_W - BANK_W - ROW_W,
  localparam int COL_W      = COLHI_W + GRAN_LG,
  localparam int MAX_PIECES = ((1 << LEN_W) - 2) / (1 << GRAN_LG) + 2,
  localparam int SEQ_W      = $clog2(MAX_PIECES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqBursts,
  output logic              subValid,
  input  logic              subReady,
  output logic [CH_W-1:0]   subChannel,
  output logic [ID_W-1:0]   subId,
  output logic [SEQ_W-1:0]  subSeq,
  output logic              subWrite,
  output logic [BANK_W-1:0] subBank,
  output logic [ROW_W-1:0]  subRow,
  output logic [COL_W-1:0]  subCol,
  output logic [CNT_W-1:0]  subBursts,
  input  logic              rbAvail,
  output logic              rbReserve
);

  split_strobe_t strobe;
  split_status_t status;

  mreq_split_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqEmpty (reqBursts == '0),
    .subReady (subReady),
    .rbAvail  (rbAvail),
    .status   (status),
    .reqReady (reqReady),
    .subValid (subValid),
    .rbReserve(rbReserve),
    .strobe   (strobe)
  );

  mreq_split_dp #(
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .LEN_W   (LEN_W),
    .BURST_LG(BURST_LG),
    .GRAN_LG (GRAN_LG),
    .CH_W    (CH_W),
    .BANK_W  (BANK_W),
    .ROW_W   (ROW_W),
    .SEQ_W   (SEQ_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqId     (reqId),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqBursts (reqBursts),
    .status    (status),
    .subChannel(subChannel),
    .subId     (subId),
    .subSeq    (subSeq),
    .subWrite  (subWrite),
    .subBank   (subBank),
    .subRow    (subRow),
    .subCol    (subCol),
    .subBursts (subBursts)
  );

endmodule

// File: rtl/memreq_splitter_chk.sv
module memreq_splitter_chk #(
  parameter int ID_W    = 8,
  parameter int CH_W    = 3,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 9,
  parameter int SEQ_W   = 3,
  parameter int GRAN_LG = 3,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              subValid,
  input logic              subReady,
  input logic [CH_W-1:0]   subChannel,
  input logic [ID_W-1:0]   subId,
  input logic [SEQ_W-1:0]  subSeq,
  input logic              subWrite,
  input logic [BANK_W-1:0] subBank,
  input logic [ROW_W-1:0]  subRow,
  input logic [COL_W-1:0]  subCol,
  input logic [CNT_W-1:0]  subBursts,
  input logic              rbAvail,
  input logic              rbReserve
);

  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> !reqReady);

  // R4
  piece_in_granule_chk: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> (subBursts != '0) &&
      ((int'(subCol[GRAN_LG-1:0]) + int'(subBursts)) <= (1 << GRAN_LG)));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subReady) |=> (!subValid || subSeq == SEQ_W'($past(subSeq) + 1'b1)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !subReady && (subWrite || rbAvail)) |=>
      (!rbAvail && !subWrite) || (subValid && $stable(subChannel) && $stable(subId) &&
      $stable(subSeq) && $stable(subBank) && $stable(subRow) && $stable(subCol) &&
      $stable(subBursts)));

  // R7
  read_needs_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !subWrite) |-> rbAvail);

  // R8
  reserve_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rbReserve |-> (subValid && subReady && !subWrite));

  // R8
  read_handoff_reserves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subReady && !subWrite) |-> rbReserve);

endmodule

bind memreq_splitter memreq_splitter_chk #(
  .ID_W   (ID_W),
  .CH_W   (CH_W),
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .SEQ_W  (SEQ_W),
  .GRAN_LG(GRAN_LG),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .subValid  (subValid),
  .subReady  (subReady),
  .subChannel(subChannel),
  .subId     (subId),
  .subSeq    (subSeq),
  .subWrite  (subWrite),
  .subBank   (subBank),
  .subRow    (subRow),
  .subCol    (subCol),
  .subBursts (subBursts),
  .rbAvail   (rbAvail),
  .rbReserve (rbReserve)
);

// File: tb/memreq_splitter_bench.sv
module memreq_splitter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqId = '0;
  logic        reqWrite = 1'b0;
  logic [27:0] reqAddr = '0;
  logic [4:0]  reqBursts = '0;
  logic        subValid;
  logic        subReady = 1'b0;
  logic [2:0]  subChannel;
  logic [7:0]  subId;
  logic [2:0]  subSeq;
  logic        subWrite;
  logic [2:0]  subBank;
  logic [7:0]  subRow;
  logic [8:0]  subCol;
  logic [3:0]  subBursts;
  logic        rbAvail = 1'b0;
  logic        rbReserve;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  memreq_splitter u_memreq_splitter (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBursts(reqBursts),
    .subValid(subValid), .subReady(subReady), .subChannel(subChannel), .subId(subId),
    .subSeq(subSeq), .subWrite(subWrite), .subBank(subBank), .subRow(subRow),
    .subCol(subCol), .subBursts(subBursts), .rbAvail(rbAvail), .rbReserve(rbReserve)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // snapshot of all piece fields packed for the R6 stability check
  function automatic logic [47:0] fieldSnap();
    return {subChannel, subId, subSeq, subWrite, subBank, subRow, subCol, subBursts};
  endfunction

  task automatic checkFields(input logic [22:0] ba, input int n, input logic [7:0] id,
                             input bit wr, input int seq);
    check(subValid == 1'b1, "R7 piece shown", subValid, 1);
    check(subChannel == ba[5:3], "R3 channel", subChannel, ba[5:3]);
    check(subBank == ba[8:6], "R3 bank", subBank, ba[8:6]);
    check(subCol == {ba[14:9], ba[2:0]}, "R3 column", subCol, {ba[14:9], ba[2:0]});
    check(subRow == ba[22:15], "R3 row", subRow, ba[22:15]);
    check(int'(subBursts) == n, "R4 bursts", subBursts, n);
    check(subId == id && subWrite == wr, "R5 id/type", {subId, subWrite}, {id, wr});
    check(int'(subSeq) == seq, "R5 seq", subSeq, seq);
  endtask

  task automatic runReq(input logic [7:0] id, input bit wr, input logic [22:0] startBa,
                        input int len, input bit stallMix);
    logic [22:0] ba;
    int rem;
    int seq;
    logic [47:0] snap;
    @(negedge clk);
    reqValid  = 1'b1;
    reqId     = id;
    reqWrite  = wr;
    reqAddr   = {startBa, id[4:0]};   // R3: low five bits are junk
    reqBursts = 5'(len);
    subReady  = 1'b0;
    rbAvail   = 1'b0;
    #1;
    check(reqReady == 1'b1, "R2 ready when idle", reqReady, 1);
    ba  = startBa;
    rem = len;
    seq = 0;
    while (rem > 0) begin
      automatic int left = 8 - int'(ba[2:0]);
      automatic int n = (rem < left) ? rem : left;
      if (stallMix && ((seq + len) % 2 == 0)) begin
        @(negedge clk);
        reqValid = 1'b1;
        reqId    = ~id;
        reqWrite = ~wr;
        subReady = 1'b0;
        rbAvail  = 1'b0;
        #1;
        check(reqReady == 1'b0, "R2 busy refuses", reqReady, 0);
        check(subValid == wr, "R7 read gated by buffer", subValid, wr);
        check(rbReserve == 1'b0, "R8 no reserve while stalled", rbReserve, 0);
      end
      @(negedge clk);
      reqValid = 1'b0;
      subReady = 1'b0;
      rbAvail  = 1'b1;
      #1;
      checkFields(ba, n, id, wr, seq);
      check(rbReserve == 1'b0, "R8 no reserve without ready", rbReserve, 0);
      snap = fieldSnap();
      @(negedge clk);
      subReady = 1'b1;
      rbAvail  = wr ? 1'b0 : 1'b1;
      #1;
      check(subValid == 1'b1 && fieldSnap() == snap, "R6 hold across stall",
            fieldSnap(), snap);
      check(rbReserve == !wr, "R8 reserve on read handoff", rbReserve, !wr);
      ba  = ba + 23'(n);
      rem = rem - n;
      seq++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    subReady = 1'b0;
    rbAvail  = 1'b1;
    #1;
    if (len == 0) begin
      check(subValid == 1'b0 && reqReady == 1'b1, "R10 empty request", {subValid, reqReady}, 1);
    end else begin
      check(subValid == 1'b0 && reqReady == 1'b1, "R9 done after last piece",
            {subValid, reqReady}, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(subValid == 1'b0, "R1 subValid reset", subValid, 0);
    check(reqReady == 1'b1, "R1 reqReady reset", reqReady, 1);
    check(rbReserve == 1'b0, "R1 rbReserve reset", rbReserve, 0);

    // sweep start position over two granules, every length, both types
    for (int s = 0; s < 16; s++) begin
      for (int len = 0; len < 32; len++) begin
        for (int w = 0; w < 2; w++) begin
          automatic logic [22:0] base = 23'((len * 4093 + s * 977) % 8000000);
          automatic logic [22:0] start = {base[22:4], 4'(s)};
          runReq(8'(s * 32 + len), w[0], start, len, ((s + w) % 3) != 0);
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule